// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting timer channel reached through a byte-wide port. It follows the style of the classic PC interval timer. Software first writes a control byte. That byte names the channel, the access type and the counting mode. Software then loads the count as a pair of data bytes, low byte first. The count is read back as a pair of bytes, low byte first. A latch command freezes a snapshot of the count, so that both bytes come from the same instant.

The counter moves only on cycles where the `tick_en` strobe is high. That strobe is a fixed-rate enable derived elsewhere, nominally about 1.19 MHz. In one-shot mode, reaching the end sets a status bit. In periodic mode, reaching the end reloads the programmed value and counting carries on. A control byte that addresses an illegal channel, or that uses an access type this channel does not support, raises a one-cycle error pulse and changes nothing.

Top module: `pit_channel`

## Requirements
- R1: After reset the count is 0, the status byte is 0x00, `err_o` is 0, no latch is pending, and both the write and read byte pointers point at the low byte, so `rd_data_o` reads 0x00.
- R2: A control byte is split into three fields: bits [7:6] are the channel select, bits [5:4] are the access type and bits [3:1] are the mode. A control byte whose select is neither `CHAN_ID` nor 3 belongs to another channel and has no effect at all: it does not change the mode and does not latch.
- R3: A control byte with access type 3 stores the mode and returns both byte pointers to the low byte. The first data write after it is kept as the low byte and leaves the count unchanged. The second data write supplies the high byte; on the next cycle the count holds the full 16-bit value, counting starts and the write pointer returns to the low byte.
- R4: While counting, the count drops by exactly one on each cycle with `tick_en` high. It does not move on other cycles, and it never moves before the first load.
- R5: A control byte with access type 0 is a latch command. When no latch is pending, it copies the current count into a holding register, marks a latch as pending and returns the read pointer to the low byte.
- R6: While a latch is pending, any further latch command is ignored: neither the held value nor the read pointer changes.
- R7: Each read pulse on `rd_en` advances the read pointer, so reads alternate between low byte and high byte. While a latch is pending, reads return the held bytes. The latch is released by the read of the high byte.
- R8: When no latch is pending, reads return the bytes of the live count, still alternating low byte then high byte.
- R9: In any mode other than 2, a tick while the count is 1 takes the count to 0, sets status bit 5 (`status_o` = 0x20) and stops counting. The count then stays at 0. Completing a new load clears the status.
- R10: In mode 2, a tick while the count is 1 reloads the last programmed value instead of reaching 0, and counting continues with the status left at 0.
- R11: A control byte with select 3, or with select `CHAN_ID` and access type 1 or 2, drives `err_o` high for exactly one cycle. It changes neither the mode, the latch nor the pointers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-down strobe, one cycle per timer tick |
| wr_en | input | 1 | Byte write strobe |
| wr_ctrl | input | 1 | 1: the byte is a control byte; 0: the byte is a data byte |
| wr_data | input | BYTE_W | Written byte |
| rd_en | input | 1 | Read strobe; advances the read byte pointer |
| rd_data_o | output | BYTE_W | Byte currently selected for reading |
| status_o | output | BYTE_W | Status byte; bit 5 is set on one-shot expiry |
| err_o | output | 1 | One-cycle pulse for an unsupported control byte |

## Verification
The hardest case to reach is a latch that is still pending and half-read while the live count keeps moving. The stimulus latches, ticks, reads only the low byte, issues a second latch, ticks again and then reads the high byte. The bytes read must all come from the first snapshot, and the next read pair must show the live count. A second sequence reads the live low byte and then latches, to show that the latch pulls the read pointer back to the low byte. Expiry is reached by loading a count of 3 and ticking across the end in both modes. Before that, a control byte aimed at another channel tries to set periodic mode; the channel must still expire as a one-shot.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // access-type encodings from control bits [5:4]
   localparam logic [1:0] ACC_LATCH = 2'd0;
   localparam logic [1:0] ACC_LOW   = 2'd1;
   localparam logic [1:0] ACC_HIGH  = 2'd2;
   localparam logic [1:0] ACC_PAIR  = 2'd3;
   // select value that is always illegal
   localparam logic [1:0] SEL_BAD   = 2'd3;
   // mode that reloads on expiry
   localparam logic [2:0] MODE_PERIODIC = 3'd2;
   localparam int unsigned STATUS_BIT = 5;

   typedef struct packed {
      logic [1:0] sel;
      logic [1:0] acc;
      logic [2:0] mode;
   } ctrl_fields_t;
endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
   import pit_pkg::*;
#(
   parameter int unsigned CHAN_ID = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_wr_i,
   input  logic [6:0] cw_i,
   output logic       latch_o,
   output logic       mode_wr_o,
   output logic [2:0] mode_o,
   output logic       err_o
);
   localparam logic [1:0] MY_SEL = 2'(CHAN_ID);

   ctrl_fields_t cw;
   logic         mine;

   assign cw        = ctrl_fields_t'(cw_i);
   assign mine      = ctrl_wr_i && (cw.sel == MY_SEL);
   assign latch_o   = mine && (cw.acc == ACC_LATCH);
   assign mode_wr_o = mine && (cw.acc == ACC_PAIR);
   assign mode_o    = cw.mode;
   assign err_o     = ctrl_wr_i && ((cw.sel == SEL_BAD) ||
                      (mine && (cw.acc == ACC_LOW || cw.acc == ACC_HIGH)));

   // R11
   cmd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({latch_o, mode_wr_o, err_o}));
endmodule

// File: rtl/pit_byte_port.sv
module pit_byte_port #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_reset_i,
   input  logic              data_wr_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic              latch_i,
   input  logic              rd_en_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic              load_o,
   output logic [CNT_W-1:0]  load_val_o,
   output logic [BYTE_W-1:0] rd_data_o
);
   logic              wr_hi_q, rd_hi_q, pend_q;
   logic [BYTE_W-1:0] low_q;
   logic [CNT_W-1:0]  hold_q;
   logic [CNT_W-1:0]  src;

   assign load_o     = data_wr_i && wr_hi_q;
   assign load_val_o = {data_i, low_q};
   assign src        = pend_q ? hold_q : count_i;
   assign rd_data_o  = rd_hi_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_hi_q <= 1'b0;
         low_q   <= '0;
      end else if (ptr_reset_i) begin
         wr_hi_q <= 1'b0;
      end else if (data_wr_i) begin
         wr_hi_q <= !wr_hi_q;
         if (!wr_hi_q) low_q <= data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_hi_q <= 1'b0;
         pend_q  <= 1'b0;
         hold_q  <= '0;
      end else if (latch_i && !pend_q) begin
         hold_q  <= count_i;
         pend_q  <= 1'b1;
         rd_hi_q <= 1'b0;
      end else if (ptr_reset_i) begin
         rd_hi_q <= 1'b0;
      end else if (rd_en_i) begin
         rd_hi_q <= !rd_hi_q;
         if (rd_hi_q) pend_q <= 1'b0;
      end
   end

   // R6
   held_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> $stable(hold_q));
   // R7
   latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && rd_en_i && rd_hi_q && !ptr_reset_i) |=> !pend_q);
endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter
   import pit_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter bit          EN_PERIODIC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [2:0]       mode_i,
   output logic [CNT_W-1:0] count_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] count_q, reload_q;
   logic             run_q, done_q, periodic;

   generate
      if (EN_PERIODIC) begin : g_periodic
         assign periodic = (mode_i == MODE_PERIODIC);
      end else begin : g_oneshot
         logic unused_mode;
         assign unused_mode = ^mode_i;
         assign periodic    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= '0;
         reload_q <= '0;
         run_q    <= 1'b0;
         done_q   <= 1'b0;
      end else if (load_i) begin
         count_q  <= load_val_i;
         reload_q <= load_val_i;
         run_q    <= 1'b1;
         done_q   <= 1'b0;
      end else if (tick_i && run_q) begin
         if (count_q == ONE) begin
            if (periodic) begin
               count_q <= reload_q;
            end else begin
               count_q <= '0;
               run_q   <= 1'b0;
               done_q  <= 1'b1;
            end
         end else begin
            count_q <= count_q - ONE;
         end
      end
   end

   assign count_o = count_q;
   assign done_o  = done_q;

   // R3
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (count_q == $past(load_val_i)) && !done_q);
   // R9
   oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && run_q && count_q == ONE && !periodic && !load_i)
      |=> done_q && count_q == '0);
   // R10
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && run_q && count_q == ONE && periodic && !load_i)
      |=> count_q == reload_q && !done_q);
   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i) |=> $stable(count_q));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned CHAN_ID     = 0,
   parameter bit          EN_PERIODIC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              wr_ctrl,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_data_o,
   output logic [BYTE_W-1:0] status_o,
   output logic              err_o
);
   initial begin
      assert (CNT_W == 2 * BYTE_W) else $error("CNT_W must be twice BYTE_W");
      assert (BYTE_W >= 8)         else $error("control byte needs 8 bits");
      assert (CHAN_ID < 3)         else $error("CHAN_ID must be 0..2");
   end

   logic             latch, mode_wr, err_cmd, load, done;
   logic [2:0]       mode_new;
   logic [2:0]       mode_q;
   logic             err_q;
   logic [CNT_W-1:0] count, load_val;
   logic [6:0]       cw;

   assign cw = wr_data[7:1];

   generate
      if (BYTE_W > 8) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^wr_data[BYTE_W-1:8];
      end
   endgenerate

   pit_ctrl_decode #(.CHAN_ID(CHAN_ID)) u_dec (
      .clk(clk), .rst_n(rst_n), .ctrl_wr_i(wr_en && wr_ctrl), .cw_i(cw),
      .latch_o(latch), .mode_wr_o(mode_wr), .mode_o(mode_new), .err_o(err_cmd)
   );

   pit_byte_port #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_port (
      .clk(clk), .rst_n(rst_n), .ptr_reset_i(mode_wr),
      .data_wr_i(wr_en && !wr_ctrl), .data_i(wr_data), .latch_i(latch),
      .rd_en_i(rd_en), .count_i(count), .load_o(load),
      .load_val_o(load_val), .rd_data_o(rd_data_o)
   );

   pit_down_counter #(.CNT_W(CNT_W), .EN_PERIODIC(EN_PERIODIC)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .load_i(load),
      .load_val_i(load_val), .mode_i(mode_q), .count_o(count), .done_o(done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= err_cmd;
         if (mode_wr) mode_q <= mode_new;
      end
   end

   assign err_o = err_q;

   always_comb begin
      status_o             = '0;
      status_o[STATUS_BIT] = done;
   end

   // R11
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> $stable(mode_q));
   // R2
   foreign_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ctrl && wr_data[7:6] != 2'(CHAN_ID)) |=> $stable(mode_q));
endmodule

// File: tb/tb_pit_channel.sv
`timescale 1ns/1ps
module tb_pit_channel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0, wr_en = 1'b0, wr_ctrl = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data_o, status_o;
   logic       err_o;
   int         total = 0, bad = 0;
   bit         finished = 1'b0;

   always #2 clk = !clk;

   pit_channel dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_ctrl(wr_ctrl), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data_o(rd_data_o), .status_o(status_o), .err_o(err_o)
   );

   task automatic check(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic put(input bit is_ctrl, input logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1; wr_ctrl = is_ctrl; wr_data = b;
      @(negedge clk);
      wr_en = 1'b0; wr_ctrl = 1'b0;
   endtask

   task automatic get(output logic [7:0] b);
      @(negedge clk);
      b = rd_data_o;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic read_pair(input string req, input int exp);
      logic [7:0] lo, hi;
      get(lo);
      get(hi);
      check(req, {hi, lo}, exp);
   endtask

   task automatic t_reset;
      check("R1 rd_data", rd_data_o, 8'h00);
      check("R1 status", status_o, 8'h00);
      check("R1 err", err_o, 0);
      read_pair("R1 count", 16'h0000);
   endtask

   task automatic t_load_count;
      logic [7:0] b;
      ticks(4);
      read_pair("R4 no count before load", 16'h0000);
      put(1, 8'h30);
      put(0, 8'h34);
      get(b);
      check("R3 low write alone leaves count", b, 8'h00);
      get(b);
      put(0, 8'h12);
      read_pair("R3 R8 loaded value", 16'h1234);
      ticks(5);
      read_pair("R4 five ticks", 16'h122F);
   endtask

   task automatic t_latch;
      logic [7:0] b;
      put(1, 8'h00);
      ticks(3);
      get(b);
      check("R7 held low byte", b, 8'h2F);
      put(1, 8'h00);
      ticks(1);
      get(b);
      check("R6 R7 held high byte", b, 8'h12);
      read_pair("R8 live after release", 16'h122B);
      get(b);
      check("R8 live low", b, 8'h2B);
      put(1, 8'h00);
      ticks(2);
      read_pair("R5 latch resets read pointer", 16'h122B);
      read_pair("R8 live again", 16'h1229);
   endtask

   task automatic t_err_foreign;
      put(1, 8'hC0);
      check("R11 err on select 3", err_o, 1);
      @(negedge clk);
      check("R11 err one cycle", err_o, 0);
      put(1, 8'h10);
      check("R11 err on access 1", err_o, 1);
      put(1, 8'h80);
      check("R2 foreign latch no err", err_o, 0);
      ticks(1);
      read_pair("R2 R11 foreign latch ignored", 16'h1228);
   endtask

   task automatic t_oneshot;
      put(1, 8'h30);
      put(0, 8'h03);
      put(0, 8'h00);
      put(1, 8'hB4);
      ticks(2);
      check("R9 status before end", status_o, 8'h00);
      ticks(1);
      check("R9 R2 status at end", status_o, 8'h20);
      ticks(3);
      read_pair("R9 count stays zero", 16'h0000);
      put(0, 8'h05);
      put(0, 8'h00);
      check("R9 load clears status", status_o, 8'h00);
   endtask

   task automatic t_periodic;
      put(1, 8'h34);
      put(0, 8'h03);
      put(0, 8'h00);
      ticks(3);
      read_pair("R10 reload at end", 16'h0003);
      ticks(1);
      read_pair("R10 keeps counting", 16'h0002);
      check("R10 status stays clear", status_o, 8'h00);
      ticks(5);
      read_pair("R10 second period", 16'h0003);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got 0x0 expected 0x1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load_count();
      t_latch();
      t_err_foreign();
      t_oneshot();
      t_periodic();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule